// File: doc/BRIEF.md
# Inter-processor software interrupt dispatcher

This block lets any of up to eight processors interrupt the others, or itself, through software. A processor writes a command word that carries an interrupt number (0 to 15), a filter mode and an 8-bit target list. The write is tagged with the number of the CPU that issued it. The block keeps pending state for every combination of interrupt number, source CPU and destination CPU. Each destination then sees the interrupt on its own level IRQ line after a fixed number of cycles, set by a parameter.

A destination CPU claims work by pulsing its acknowledge strobe. The block returns the most urgent eligible entry, with the interrupt number in bits 9:0 and the raising CPU in bits 12:10. The claimed entry moves from pending to active. The CPU later hands the same word back on its end-of-interrupt port, and that clears the active entry. Each interrupt number has an 8-bit priority, where a lower value means more urgent. Each CPU has a priority mask: only entries strictly more urgent than the mask are eligible. While the active bit of an (interrupt, source, destination) entry is set, a new pending request on that same entry waits until end-of-interrupt.

Top module: `ipi_dispatch`

## Requirements
- R1: With filter mode 0 (command bits 25:24 = 0), the interrupt number in command bits 3:0 becomes pending for every CPU whose bit is set in command bits 23:16.
- R2: With filter mode 1, the interrupt becomes pending for every CPU except the issuing one, and the target list is ignored.
- R3: With filter mode 2, the interrupt becomes pending only for the issuing CPU, and the target list is ignored.
- R4: With filter mode 3, the command has no effect on any IRQ line or on any later acknowledge.
- R5: An acknowledge by CPU c returns, one cycle later, the eligible entry with the numerically lowest priority, as {source[2:0], id[9:0]}. That entry stops being pending, so the next acknowledge does not return it again.
- R6: When CPU c has no eligible entry, an acknowledge returns 1023 with source 0 (13'h03FF). After reset every acknowledge word reads this value and every IRQ line is low.
- R7: On equal priority the lower interrupt number wins. For the same number, the lower source CPU wins.
- R8: An entry is eligible for CPU c only if its priority is strictly less than c's mask. After reset all masks are 0xFF and all priorities are 0.
- R9: An IRQ line rises exactly DELAY clock edges after the edge that made an entry eligible. It stays high while any eligible entry remains, and it falls right after the edge that removes the last one.
- R10: An acknowledged entry is active. While it is active, a new request on the same (id, source, destination) is not eligible. End-of-interrupt with that {source, id} word clears the active state. Active state on one source does not block the same id from another source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_src | input | 3 | Number of the CPU issuing the command |
| cmd_word | input | 32 | Command: id 3:0, target list 23:16, filter mode 25:24 |
| prio_we | input | 1 | Priority write strobe |
| prio_id | input | 4 | Interrupt number whose priority is written |
| prio_val | input | 8 | New priority, lower is more urgent |
| mask_we | input | 1 | Mask write strobe |
| mask_cpu | input | 3 | CPU whose mask is written |
| mask_val | input | 8 | New priority mask |
| ack_req | input | 8 | Per-CPU acknowledge strobe |
| ack_word | output | 104 | Per-CPU 13-bit acknowledge result, CPU c at bits 13c+12:13c |
| eoi_req | input | 8 | Per-CPU end-of-interrupt strobe |
| eoi_word | input | 104 | Per-CPU 13-bit {source, id} to retire |
| irq | output | 8 | Per-CPU level interrupt request |

## Verification
The four filter modes are each driven with target lists that contradict the mode, so a list that is wrongly honoured or wrongly ignored shows up on the IRQ vector. Ordering is tested with several pending entries drained one acknowledge at a time. One set differs only in priority, another ties on priority and differs in id, and a third ties on id and differs in source, so each level of the ordering is exercised on its own. The mask is tested at the boundary where priority equals mask and then one step above it. The active state is tested by re-raising a claimed entry, by raising the same id from a second source, and by retiring with end-of-interrupt. IRQ edges are sampled one cycle before and at the DELAY edge.

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int NCPU  = 8,
  parameter int NID   = 16,
  parameter int PW    = 8,
  parameter int DELAY = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_src,
  input  logic [31:0]        cmd_word,
  input  logic               prio_we,
  input  logic [$clog2(NID)-1:0] prio_id,
  input  logic [PW-1:0]      prio_val,
  input  logic               mask_we,
  input  logic [2:0]         mask_cpu,
  input  logic [PW-1:0]      mask_val,
  input  logic [NCPU-1:0]    ack_req,
  output logic [NCPU*13-1:0] ack_word,
  input  logic [NCPU-1:0]    eoi_req,
  input  logic [NCPU*13-1:0] eoi_word,
  output logic [NCPU-1:0]    irq
);
  localparam int IW = $clog2(NID);
  localparam int NB = NCPU * NCPU;
  localparam int CW = $clog2(DELAY + 2);
  localparam logic [12:0] SPUR = 13'h03FF;

  logic [NID-1:0][NB-1:0] pend, act;
  logic [PW-1:0] prio [NID];
  logic [PW-1:0] mask [NCPU];

  wire [1:0]    mode    = cmd_word[25:24];
  wire [IW-1:0] cid     = cmd_word[IW-1:0];
  wire          src_ok  = 32'(cmd_src) < NCPU;
  wire [NCPU-1:0] src_oh = NCPU'(1) << cmd_src;
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd_word[31:26], cmd_word[15:IW]};

  logic [NCPU-1:0] tgt;
  always_comb begin
    case (mode)
      2'd0:    tgt = cmd_word[16 +: NCPU];
      2'd1:    tgt = ~src_oh;
      2'd2:    tgt = src_oh;
      default: tgt = '0;
    endcase
  end

  logic [NCPU-1:0] cand;
  logic [IW-1:0]   w_id  [NCPU];
  logic [2:0]      w_src [NCPU];
  logic [PW-1:0]   w_pr  [NCPU];

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      cand[c]  = 1'b0;
      w_id[c]  = '0;
      w_src[c] = '0;
      w_pr[c]  = '0;
      for (int id = 0; id < NID; id++)
        for (int s = 0; s < NCPU; s++)
          if (pend[id][s*NCPU+c] && !act[id][s*NCPU+c] && prio[id] < mask[c] &&
              (!cand[c] || prio[id] < w_pr[c])) begin
            cand[c]  = 1'b1;
            w_id[c]  = IW'(id);
            w_src[c] = 3'(s);
            w_pr[c]  = prio[id];
          end
    end
  end

  logic [9:0] e_id  [NCPU];
  logic [2:0] e_src [NCPU];
  for (genvar c = 0; c < NCPU; c++) begin : g_eoi
    assign e_id[c]  = eoi_word[c*13 +: 10];
    assign e_src[c] = eoi_word[c*13+10 +: 3];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
      for (int i = 0; i < NID; i++) prio[i] <= '0;
      for (int c = 0; c < NCPU; c++) mask[c] <= '1;
      ack_word <= {NCPU{SPUR}};
    end else begin
      for (int c = 0; c < NCPU; c++) begin
        if (ack_req[c]) begin
          if (cand[c]) begin
            pend[w_id[c]][32'(w_src[c])*NCPU+c] <= 1'b0;
            act[w_id[c]][32'(w_src[c])*NCPU+c]  <= 1'b1;
            ack_word[c*13 +: 13] <= {w_src[c], 10'(w_id[c])};
          end else begin
            ack_word[c*13 +: 13] <= SPUR;
          end
        end
        if (eoi_req[c] && 32'(e_id[c]) < NID && 32'(e_src[c]) < NCPU)
          act[e_id[c][IW-1:0]][32'(e_src[c])*NCPU+c] <= 1'b0;
      end
      if (cmd_valid && src_ok)
        for (int t = 0; t < NCPU; t++)
          if (tgt[t]) pend[cid][32'(cmd_src)*NCPU+t] <= 1'b1;
      if (prio_we) prio[prio_id] <= prio_val;
      if (mask_we && 32'(mask_cpu) < NCPU) mask[mask_cpu] <= mask_val;
    end
  end

  AST_MODE3_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && mode == 2'd3 && ack_req == '0 && eoi_req == '0 |=> $stable(pend)); // R4

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n || !cand[c]) cnt <= '0;
      else if (cnt < CW'(DELAY)) cnt <= cnt + 1'b1;
    end
    assign irq[c] = cand[c] && (cnt >= CW'(DELAY));

    AST_ACK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req[c] && cand[c] |=> ack_word[c*13 +: 10] != 10'd1023); // R5
    AST_ACK_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req[c] && !cand[c] |=> ack_word[c*13 +: 13] == SPUR); // R6
    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mask[c] == '0 |-> !irq[c]); // R8
    if (DELAY > 0) begin : g_dly
      AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[c]) |-> $past(cand[c])); // R9
    end
  end
endmodule

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;
  localparam int D = 3;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, prio_we, mask_we;
  logic [2:0] cmd_src, mask_cpu;
  logic [31:0] cmd_word;
  logic [3:0] prio_id;
  logic [7:0] prio_val, mask_val, ack_req, eoi_req, irq;
  logic [103:0] ack_word, eoi_word;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [12:0] w;

  ipi_dispatch #(.NCPU(8), .NID(16), .PW(8), .DELAY(D)) i_ipi_dispatch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
    .cmd_word(cmd_word), .prio_we(prio_we), .prio_id(prio_id), .prio_val(prio_val),
    .mask_we(mask_we), .mask_cpu(mask_cpu), .mask_val(mask_val),
    .ack_req(ack_req), .ack_word(ack_word), .eoi_req(eoi_req),
    .eoi_word(eoi_word), .irq(irq));

  task automatic chk(input string req, input [31:0] a, input [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, a, e);
    end
  endtask

  task automatic send(input [2:0] s, input [3:0] id, input [1:0] m, input [7:0] lst);
    cmd_valid = 1'b1; cmd_src = s;
    cmd_word = {6'd0, m, lst, 12'd0, id};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ack(input int c, output logic [12:0] r);
    ack_req[c] = 1'b1;
    @(negedge clk);
    ack_req[c] = 1'b0;
    r = ack_word[c*13 +: 13];
  endtask

  task automatic eoi(input int c, input [12:0] v);
    eoi_req[c] = 1'b1; eoi_word[c*13 +: 13] = v;
    @(negedge clk);
    eoi_req[c] = 1'b0;
  endtask

  task automatic set_prio(input [3:0] id, input [7:0] v);
    prio_we = 1'b1; prio_id = id; prio_val = v;
    @(negedge clk);
    prio_we = 1'b0;
  endtask

  task automatic set_mask(input [2:0] c, input [7:0] v);
    mask_we = 1'b1; mask_cpu = c; mask_val = v;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  function automatic [12:0] aw(input [2:0] s, input [9:0] id);
    return {s, id};
  endfunction

  task automatic t_reset;
    chk("R6 reset irq", 32'(irq), 32'h0);
    for (int c = 0; c < 8; c++) chk("R6 reset ack", 32'(ack_word[c*13 +: 13]), 32'h3FF);
  endtask

  task automatic t_list;
    send(3'd0, 4'd5, 2'd0, 8'h04);
    repeat (D-1) @(negedge clk);
    chk("R9 irq before delay", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R1 irq list", 32'(irq), 32'h04);
    ack(2, w);
    chk("R5 ack word", 32'(w), 32'(aw(0, 5)));
    chk("R9 irq falls", 32'(irq), 32'h0);
    ack(2, w);
    chk("R6 spurious", 32'(w), 32'h3FF);
    eoi(2, aw(0, 5));
  endtask

  task automatic t_others;
    send(3'd3, 4'd7, 2'd1, 8'h08);
    repeat (D) @(negedge clk);
    chk("R2 irq others", 32'(irq), 32'hF7);
    for (int c = 0; c < 8; c++) begin
      ack(c, w);
      chk("R2 ack", 32'(w), c == 3 ? 32'h3FF : 32'(aw(3, 7)));
      if (c != 3) eoi(c, aw(3, 7));
    end
    chk("R2 drained", 32'(irq), 32'h0);
  endtask

  task automatic t_self;
    send(3'd6, 4'd1, 2'd2, 8'h01);
    repeat (D) @(negedge clk);
    chk("R3 irq self", 32'(irq), 32'h40);
    ack(6, w);
    chk("R3 ack", 32'(w), 32'(aw(6, 1)));
    eoi(6, aw(6, 1));
  endtask

  task automatic t_mode3;
    send(3'd0, 4'd2, 2'd3, 8'hFF);
    repeat (D+2) @(negedge clk);
    chk("R4 irq", 32'(irq), 32'h0);
    ack(0, w);
    chk("R4 ack0", 32'(w), 32'h3FF);
    ack(5, w);
    chk("R4 ack5", 32'(w), 32'h3FF);
  endtask

  task automatic t_prio;
    set_prio(4'd9, 8'h10);
    set_prio(4'd2, 8'h40);
    send(3'd0, 4'd2, 2'd0, 8'h02);
    send(3'd0, 4'd9, 2'd0, 8'h02);
    repeat (D) @(negedge clk);
    ack(1, w);
    chk("R5 most urgent first", 32'(w), 32'(aw(0, 9)));
    chk("R9 irq held", 32'(irq), 32'h02);
    ack(1, w);
    chk("R5 second", 32'(w), 32'(aw(0, 2)));
    chk("R9 irq low", 32'(irq), 32'h0);
    eoi(1, aw(0, 9)); eoi(1, aw(0, 2));
    set_prio(4'd9, 8'h00); set_prio(4'd2, 8'h00);
  endtask

  task automatic t_tie;
    send(3'd0, 4'd4, 2'd0, 8'h20);
    send(3'd5, 4'd3, 2'd2, 8'h00);
    send(3'd1, 4'd3, 2'd0, 8'h20);
    send(3'd0, 4'd3, 2'd0, 8'h20);
    repeat (D) @(negedge clk);
    ack(5, w); chk("R7 tie 1", 32'(w), 32'(aw(0, 3)));
    ack(5, w); chk("R7 tie 2", 32'(w), 32'(aw(1, 3)));
    ack(5, w); chk("R7 tie 3", 32'(w), 32'(aw(5, 3)));
    ack(5, w); chk("R7 tie 4", 32'(w), 32'(aw(0, 4)));
    eoi(5, aw(0, 3)); eoi(5, aw(1, 3)); eoi(5, aw(5, 3)); eoi(5, aw(0, 4));
  endtask

  task automatic t_mask;
    set_prio(4'd11, 8'h30);
    set_mask(3'd4, 8'h30);
    send(3'd2, 4'd11, 2'd0, 8'h10);
    repeat (D+2) @(negedge clk);
    chk("R8 equal mask blocks", 32'(irq), 32'h0);
    ack(4, w);
    chk("R8 masked ack", 32'(w), 32'h3FF);
    set_mask(3'd4, 8'h31);
    repeat (D-1) @(negedge clk);
    chk("R9 mask open early", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R8 mask open", 32'(irq), 32'h10);
    ack(4, w);
    chk("R8 ack", 32'(w), 32'(aw(2, 11)));
    eoi(4, aw(2, 11));
    set_mask(3'd4, 8'hFF); set_prio(4'd11, 8'h00);
  endtask

  task automatic t_active;
    send(3'd0, 4'd5, 2'd0, 8'h04);
    repeat (D) @(negedge clk);
    ack(2, w);
    chk("R10 first claim", 32'(w), 32'(aw(0, 5)));
    send(3'd0, 4'd5, 2'd0, 8'h04);
    repeat (D+2) @(negedge clk);
    chk("R10 active blocks irq", 32'(irq), 32'h0);
    ack(2, w);
    chk("R10 active blocks ack", 32'(w), 32'h3FF);
    send(3'd1, 4'd5, 2'd0, 8'h04);
    repeat (D) @(negedge clk);
    chk("R10 other source irq", 32'(irq), 32'h04);
    ack(2, w);
    chk("R10 other source ack", 32'(w), 32'(aw(1, 5)));
    eoi(2, aw(0, 5));
    repeat (D-1) @(negedge clk);
    chk("R10 eoi early", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R10 eoi releases", 32'(irq), 32'h04);
    ack(2, w);
    chk("R10 re-claim", 32'(w), 32'(aw(0, 5)));
    eoi(2, aw(0, 5)); eoi(2, aw(1, 5));
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 0; cmd_src = 0; cmd_word = 0;
    prio_we = 0; prio_id = 0; prio_val = 0; mask_we = 0; mask_cpu = 0; mask_val = 0;
    ack_req = 0; eoi_req = 0; eoi_word = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_list;
    t_others;
    t_self;
    t_mode3;
    t_prio;
    t_tie;
    t_mask;
    t_active;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule